// File: doc/BRIEF.md
# Round-Robin Sub-Chain Scan Self-Test Controller

This controller runs a pseudo-random scan self-test with low switching activity. Every scan chain of the circuit under test is split into `NUM_SUB` equal sub-chains. The controller gives a clock enable to exactly one sub-chain at a time. All other sub-chains keep their contents. The enable walks across the sub-chains in ascending order, first for shifting and then again for capture.

A shift register with linear feedback drives one scan-in bit per chain. It can be reloaded with a stored seed whenever no sub-chain is shifting, so that deterministic patterns can be applied.

A multiple-input signature register compacts the scan-out bits of every chain during each shift cycle. Its value is presented on the signature port. It is final in the cycle where the one-cycle done flag is high.

For each pattern the sequence has two halves. First, sub-chain k shifts for `SUB_LEN` cycles, for k = 0 up to `NUM_SUB`-1. Then each sub-chain in the same order receives a one-cycle capture pulse. After `NUM_PAT` patterns the controller raises done for one cycle and goes back to idle.

Top module: `rr_scan_bist`

## Requirements
- R1: After reset the controller is idle: all sub-chain enables, scanEn and done are 0, the signature is 0 and the pattern generator holds the value 1. This makes scanIn equal to 1 in bit 0 and 0 in all other bits.
- R2: At most one bit of subClkEn is 1 in any cycle.
- R3: A start pulse while idle begins a pattern. Sub-chain k (bit k of subClkEn) is enabled with scanEn=1 for exactly SUB_LEN consecutive cycles. This runs for k = 0, 1, …, NUM_SUB-1 in ascending order.
- R4: After the last shift cycle of a pattern, each sub-chain k in ascending order gets exactly one cycle with bit k of subClkEn set and scanEn=0.
- R5: The shift and capture sequence repeats for NUM_PAT patterns. done is 1 for exactly the single cycle after the last capture, and the controller is idle the cycle after that.
- R6: scanIn[c] equals bit c of the pattern generator state G. G changes only on shift cycles and on seed loads. In a shift cycle, G becomes {G[W-2:0], parity(G & LFSR_TAPS)}.
- R7: When seedValid is 1 in a cycle where scanEn is 0, G takes seedData on the next edge. An all-zero seedData loads the value 1 instead.
- R8: seedValid in a cycle where scanEn is 1 is ignored, and G advances as in R6.
- R9: An accepted start clears the signature S to 0. In every shift cycle, S becomes {S[W-2:0], parity(S & MISR_TAPS)} XOR the zero-extended scanOut, with chain c entering bit c. At all other times S holds.
- R10: A start pulse while a test is running or during the done cycle has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test run (accepted when idle) |
| seedValid | input | 1 | Request to load seedData into the pattern generator |
| seedData | input | LFSR_W | Stored seed value |
| scanOut | input | NUM_CHAINS | Scan-out bit of each chain from the circuit under test |
| subClkEn | output | NUM_SUB | Clock enable per sub-chain, at most one set |
| scanEn | output | 1 | 1 = shift, 0 = capture or idle |
| scanIn | output | NUM_CHAINS | Scan-in bit for each chain |
| done | output | 1 | One-cycle pulse after the final capture |
| signature | output | MISR_W | Compacted response signature |

## Verification
The hardest situation to reach from the ports is a seed request or a start pulse that lands in one exact phase of the sequence. Examples are the last shift cycle of a sub-chain, a capture cycle, or the single done cycle. Each of these decides whether the request takes effect.

The stimulus keeps seedValid, start and scanOut random in every cycle across several full runs. Every phase therefore meets every request many times. Directed steps add a zero seed in idle and a start pulse held through a whole run. A cycle-accurate bench model follows the sequence and checks every output on every cycle.

// File: rtl/rr_scan_bist_pkg.sv
package rr_scan_bist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CAPT  = 2'd2,
    ST_DONE  = 2'd3
  } bistState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;    // shift cycle: step generator and compactor
    logic loadSeed;   // load stored seed into generator
    logic clearSig;   // clear compactor at start of a run
  } bistStrobes_t;

endpackage

// File: rtl/rr_scan_bist_ctrl.sv
module rr_scan_bist_ctrl
  import rr_scan_bist_pkg::*;
#(
  parameter int NUM_SUB = 4,
  parameter int SUB_LEN = 8,
  parameter int NUM_PAT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               seedValid,
  output logic [NUM_SUB-1:0] subClkEn,
  output logic               scanEn,
  output logic               done,
  output bistStrobes_t       strobes
);

  localparam int SUB_W = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1;
  localparam int CNT_W = (SUB_LEN > 1) ? $clog2(SUB_LEN) : 1;
  localparam int PAT_W = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1;
  localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(NUM_SUB - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SUB_LEN - 1);
  localparam logic [PAT_W-1:0] LAST_PAT = PAT_W'(NUM_PAT - 1);

  if (NUM_SUB < 2) begin : g_bad_split
    $error("NUM_SUB must be at least 2");
  end

  bistState_e       stateQ, stateD;
  logic [SUB_W-1:0] subQ, subD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic [PAT_W-1:0] patQ, patD;
  logic             subActive;

  always_comb begin
    stateD = stateQ;
    subD   = subQ;
    cntD   = cntQ;
    patD   = patQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          stateD = ST_SHIFT;
          subD   = '0;
          cntD   = '0;
          patD   = '0;
        end
      end
      ST_SHIFT: begin
        if (cntQ == LAST_CNT) begin
          cntD = '0;
          subD = (subQ == LAST_SUB) ? '0 : subQ + 1'b1;
          if (subQ == LAST_SUB) stateD = ST_CAPT;
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      ST_CAPT: begin
        if (subQ == LAST_SUB) begin
          subD = '0;
          if (patQ == LAST_PAT) begin
            stateD = ST_DONE;
          end else begin
            stateD = ST_SHIFT;
            patD   = patQ + 1'b1;
          end
        end else begin
          subD = subQ + 1'b1;
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      subQ   <= '0;
      cntQ   <= '0;
      patQ   <= '0;
    end else begin
      stateQ <= stateD;
      subQ   <= subD;
      cntQ   <= cntD;
      patQ   <= patD;
    end
  end

  assign subActive = (stateQ == ST_SHIFT) || (stateQ == ST_CAPT);

  for (genvar k = 0; k < NUM_SUB; k++) begin : g_sub_en
    assign subClkEn[k] = subActive && (subQ == SUB_W'(k));
  end

  assign scanEn = (stateQ == ST_SHIFT);
  assign done   = (stateQ == ST_DONE);

  always_comb begin
    strobes          = '0;
    strobes.advance  = (stateQ == ST_SHIFT);
    strobes.loadSeed = seedValid && (stateQ != ST_SHIFT);
    strobes.clearSig = start && (stateQ == ST_IDLE);
  end

  // R2: never more than one sub-chain clocked
  a_r2_one_sub_max: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(subClkEn));

  // R3: a shift cycle always drives exactly one sub-chain
  a_r3_shift_one_sub: assert property (@(posedge clk) disable iff (!rstN)
    scanEn |-> ($countones(subClkEn) == 1));

  // R4: capture phase opens on sub-chain 0
  a_r4_capture_first: assert property (@(posedge clk) disable iff (!rstN)
    $fell(scanEn) && (|subClkEn) |-> subClkEn[0]);

  // R5: done is a single-cycle pulse followed by idle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !scanEn && (subClkEn == '0)));

endmodule

// File: rtl/rr_scan_bist_dp.sv
module rr_scan_bist_dp
  import rr_scan_bist_pkg::*;
#(
  parameter int              NUM_CHAINS = 4,
  parameter int              LFSR_W     = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter int              MISR_W     = 16,
  parameter logic [MISR_W-1:0] MISR_TAPS = 16'hB400
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bistStrobes_t          strobes,
  input  logic [LFSR_W-1:0]     seedData,
  input  logic [NUM_CHAINS-1:0] scanOut,
  output logic [NUM_CHAINS-1:0] scanIn,
  output logic [MISR_W-1:0]     signature
);

  localparam logic [LFSR_W-1:0] GEN_ONE = LFSR_W'(1);

  if (NUM_CHAINS > LFSR_W || NUM_CHAINS > MISR_W) begin : g_bad_width
    $error("NUM_CHAINS must not exceed LFSR_W or MISR_W");
  end

  logic [LFSR_W-1:0] genQ, genStep;
  logic [MISR_W-1:0] sigQ, sigStep, inject;

  assign genStep = {genQ[LFSR_W-2:0], ^(genQ & LFSR_TAPS)};

  always_comb begin
    inject = '0;
    for (int c = 0; c < NUM_CHAINS; c++) inject[c] = scanOut[c];
  end

  assign sigStep = {sigQ[MISR_W-2:0], ^(sigQ & MISR_TAPS)} ^ inject;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genQ <= GEN_ONE;
    end else if (strobes.loadSeed) begin
      genQ <= (seedData == '0) ? GEN_ONE : seedData;
    end else if (strobes.advance) begin
      genQ <= genStep;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sigQ <= '0;
    end else if (strobes.clearSig) begin
      sigQ <= '0;
    end else if (strobes.advance) begin
      sigQ <= sigStep;
    end
  end

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_scan_in
    assign scanIn[c] = genQ[c];
  end

  assign signature = sigQ;

  // R7: the generator never locks up in the all-zero state
  a_r7_gen_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    genQ != '0);

  // R6: without shift or load the generator holds
  a_r6_gen_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advance && !strobes.loadSeed) |=> $stable(genQ));

  // R8: a seed load never coincides with a shift cycle
  a_r8_no_load_in_shift: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |-> !strobes.loadSeed);

  // R9: signature holds outside shift cycles and clears
  a_r9_sig_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advance && !strobes.clearSig) |=> $stable(sigQ));

endmodule

// File: rtl/rr_scan_bist.sv
module rr_scan_bist
  import rr_scan_bist_pkg::*;
#(
  parameter int                NUM_SUB    = 4,
  parameter int                SUB_LEN    = 8,
  parameter int                NUM_PAT    = 16,
  parameter int                NUM_CHAINS = 4,
  parameter int                LFSR_W     = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS  = 16'hB400,
  parameter int                MISR_W     = 16,
  parameter logic [MISR_W-1:0] MISR_TAPS  = 16'hB400
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  seedValid,
  input  logic [LFSR_W-1:0]     seedData,
  input  logic [NUM_CHAINS-1:0] scanOut,
  output logic [NUM_SUB-1:0]    subClkEn,
  output logic                  scanEn,
  output logic [NUM_CHAINS-1:0] scanIn,
  output logic                  done,
  output logic [MISR_W-1:0]     signature
);

  bistStrobes_t strobes;

  rr_scan_bist_ctrl #(
    .NUM_SUB (NUM_SUB),
    .SUB_LEN (SUB_LEN),
    .NUM_PAT (NUM_PAT)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .seedValid (seedValid),
    .subClkEn  (subClkEn),
    .scanEn    (scanEn),
    .done      (done),
    .strobes   (strobes)
  );

  rr_scan_bist_dp #(
    .NUM_CHAINS (NUM_CHAINS),
    .LFSR_W     (LFSR_W),
    .LFSR_TAPS  (LFSR_TAPS),
    .MISR_W     (MISR_W),
    .MISR_TAPS  (MISR_TAPS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .seedData  (seedData),
    .scanOut   (scanOut),
    .scanIn    (scanIn),
    .signature (signature)
  );

endmodule

// File: tb/rr_scan_bist_tb_top.sv
module rr_scan_bist_tb_top;

  localparam int N  = 4;
  localparam int L  = 5;
  localparam int P  = 3;
  localparam int C  = 4;
  localparam int W  = 16;
  localparam logic [W-1:0] TAPS = 16'hB400;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         seedValid = 1'b0;
  logic [W-1:0] seedData = '0;
  logic [C-1:0] scanOut = '0;
  logic [N-1:0] subClkEn;
  logic         scanEn;
  logic [C-1:0] scanIn;
  logic         done;
  logic [W-1:0] signature;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // model state: 0 idle, 1 shift, 2 capture, 3 done
  int           mState = 0;
  int           mSub = 0, mCnt = 0, mPat = 0;
  logic [W-1:0] mGen = 16'h0001;
  logic [W-1:0] mSig = '0;

  always #2 clk = ~clk;

  rr_scan_bist #(
    .NUM_SUB(N), .SUB_LEN(L), .NUM_PAT(P), .NUM_CHAINS(C),
    .LFSR_W(W), .LFSR_TAPS(TAPS), .MISR_W(W), .MISR_TAPS(TAPS)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .seedValid(seedValid),
    .seedData(seedData), .scanOut(scanOut), .subClkEn(subClkEn),
    .scanEn(scanEn), .scanIn(scanIn), .done(done), .signature(signature)
  );

  function automatic logic [W-1:0] genNext(logic [W-1:0] g);
    return {g[W-2:0], ^(g & TAPS)};
  endfunction

  function automatic logic [W-1:0] sigNext(logic [W-1:0] s, logic [C-1:0] so);
    logic [W-1:0] inj;
    inj = '0;
    for (int c = 0; c < C; c++) inj[c] = so[c];
    return {s[W-2:0], ^(s & TAPS)} ^ inj;
  endfunction

  function automatic logic [N-1:0] expEn();
    return (mState == 1 || mState == 2) ? N'(1) << mSub : '0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    check("R2/R3/R4 subClkEn", 32'(subClkEn), 32'(expEn()));
    check("R3/R4 scanEn", 32'(scanEn), 32'(mState == 1));
    check("R5 done", 32'(done), 32'(mState == 3));
    check("R6/R7/R8 scanIn", 32'(scanIn), 32'(mGen[C-1:0]));
    check("R9 signature", 32'(signature), 32'(mSig));
  endtask

  // one clock: check current outputs, drive inputs, advance model
  task automatic step(input logic st, input logic sv, input logic [W-1:0] sd,
                      input logic [C-1:0] so);
    checkAll();
    start = st; seedValid = sv; seedData = sd; scanOut = so;
    case (mState)
      0: begin
        if (sv) mGen = (sd == '0) ? 16'h0001 : sd;
        if (st) begin mState = 1; mSub = 0; mCnt = 0; mPat = 0; mSig = '0; end
      end
      1: begin
        mGen = genNext(mGen);
        mSig = sigNext(mSig, so);
        if (mCnt == L-1) begin
          mCnt = 0;
          if (mSub == N-1) begin mSub = 0; mState = 2; end
          else mSub++;
        end else mCnt++;
      end
      2: begin
        if (sv) mGen = (sd == '0) ? 16'h0001 : sd;
        if (mSub == N-1) begin
          mSub = 0;
          if (mPat == P-1) mState = 3;
          else begin mPat++; mState = 1; end
        end else mSub++;
      end
      default: begin
        if (sv) mGen = (sd == '0) ? 16'h0001 : sd;
        mState = 0;
      end
    endcase
    @(negedge clk);
  endtask

  task automatic randomRun(input int cycles, input int seedPct, input int startPct);
    for (int i = 0; i < cycles; i++) begin
      step(($urandom % 100) < startPct, ($urandom % 100) < seedPct,
           W'($urandom), C'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    checkAll();
    check("R1 idle subClkEn", 32'(subClkEn), 32'h0);
    check("R1 scanIn seed", 32'(scanIn), 32'h1);
    rstN = 1'b1;
    @(negedge clk);
    // R7: seed load in idle, then zero seed maps to 1
    step(1'b0, 1'b1, 16'hA5C3, '0);
    step(1'b0, 1'b0, 16'h0000, '0);
    check("R7 seed loaded", 32'(scanIn), 32'h3);
    step(1'b0, 1'b1, 16'h0000, '0);
    step(1'b0, 1'b0, 16'h0000, '0);
    check("R7 zero seed", 32'(scanIn), 32'h1);
    // R3/R4/R5/R10: full run with start held high all the way
    step(1'b1, 1'b1, 16'h1234, 4'h9);
    for (int i = 0; i < P*(N*L+N) + 2; i++) step(1'b1, 1'b0, '0, C'($urandom));
    // R8: seed requests every cycle of a run, including shifts
    step(1'b1, 1'b0, '0, '0);
    for (int i = 0; i < P*(N*L+N) + 3; i++) step(1'b0, 1'b1, W'($urandom), C'($urandom));
    // random mix of everything
    randomRun(600, 30, 10);
    // R5: long idle gap, then a clean run to done
    randomRun(10, 50, 0);
    step(1'b1, 1'b0, '0, '0);
    randomRun(P*(N*L+N) + 4, 40, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule